// File: doc/BRIEF.md
# Jump and Subroutine Linkage Unit

This unit carries out the three control-transfer instructions of a 16-bit minicomputer whose register R6 is the stack pointer and whose register R7 is the program counter: the plain jump, the jump to subroutine with a link register, and the return from subroutine. An address generator outside the unit has already resolved the destination address. The unit receives that address together with the instruction word on a one-cycle `start` strobe. It then walks the instruction through a fixed sequence of register file writes and stack memory cycles. All changes to the PC are made as writes to R7 through the register write port.

A jump whose destination names a register rather than a memory location cannot be executed. For that case the unit leaves every register unchanged and raises a one-cycle trap request with vector octal 010. Trap servicing belongs to the surrounding core. Every instruction, including an unrecognised one, ends with a one-cycle `done` pulse. While `busy` is high a further `start` is ignored.

The register file read port is combinational: the unit drives `rf_rd_idx` and samples `rf_rd_data` in the same cycle. A memory request stays asserted with a stable address and data until `mem_ack` is seen. `mem_ack` may arrive in the same cycle as the request.

Top module: `jsl_unit`

## Requirements
- R1: While and directly after reset, `busy`, `done`, `rf_we`, `mem_req` and `trap_req` are all low.
- R2: An instruction whose bits 15:6 equal 0000000001 is a jump, and bits 5:3 give its destination mode. With a nonzero mode the unit makes exactly one register write, R7 = `dest_addr`, and makes no memory cycle and no trap.
- R3: A jump with destination mode 0 makes no register write and no memory cycle. It asserts `trap_req` for exactly one cycle with `trap_vector` = 8 (octal 010), and `done` follows in the next cycle.
- R4: An instruction whose bits 15:9 equal 0000100 is a subroutine call, with its link register in bits 8:6. It first writes R6 = R6 − 2, then makes one memory write of the link register's old value at the new R6.
- R5: After its push, the call writes the link register with the old R7 and then writes R7 = `dest_addr`, in that order. With the link register R7, the final R7 is `dest_addr`.
- R6: An instruction whose bits 15:3 equal 0000000010000 is a return, with its link register in bits 2:0. It reads memory at R6 and then makes three writes in this order: R6 = R6 + 2, R7 = the link register's old value, and the link register = the word read.
- R7: For a return through R7, the popped word is fetched before R7 is touched, and the final R7 equals the popped word.
- R8: A memory request holds `mem_req`, `mem_we` and `mem_addr` stable until `mem_ack`, and exactly one transfer completes per push or pop, whether the ack arrives at once or after wait cycles.
- R9: `done` is a one-cycle pulse. For an instruction that writes registers, it appears in the cycle directly after the last register write.
- R10: Any other instruction word produces a `done` pulse and no register write, no memory cycle and no trap.
- R11: A `start` received while `busy` is high has no effect: the running instruction completes with its own writes and a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle strobe presenting an instruction |
| instr | input | 16 | Instruction word |
| dest_addr | input | DATA_W | Resolved destination address |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_rd_idx | output | 3 | Register file read index |
| rf_rd_data | input | DATA_W | Register file read data, same cycle |
| rf_we | output | 1 | Register file write enable |
| rf_wr_idx | output | 3 | Register file write index |
| rf_wr_data | output | DATA_W | Register file write data |
| mem_req | output | 1 | Stack memory request |
| mem_we | output | 1 | 1 = write (push), 0 = read (pop) |
| mem_addr | output | DATA_W | Stack memory byte address |
| mem_wdata | output | DATA_W | Word to push |
| mem_rdata | input | DATA_W | Word popped, valid with ack |
| mem_ack | input | 1 | Memory transfer complete |
| trap_req | output | 1 | One-cycle trap request |
| trap_vector | output | DATA_W | Trap vector, 8 while trap_req is high |

## Verification
The two functions that can share a cycle are the memory request and its acknowledge. The bench's memory model answers either in the request cycle itself or after a programmed number of wait cycles. In a return through R7, the popped word and the PC load both target R7 in consecutive writes. The bench judges these cases on the ordered log of register writes, on the number of request cycles against the programmed wait, on any address change while a request is pending, and on the final register and memory contents. A second `start` is also injected while a call is waiting on memory. The bench judges it ignored when the write log and the done count match an undisturbed call.

// File: rtl/jsl_pkg.sv
// Shared types for the jump and subroutine linkage unit.
// Assumes the fixed 16-bit instruction format with 3-bit register fields.
package jsl_pkg;

    localparam int INSTR_W = 16;
    localparam int REG_AW  = 3;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_JMP,
        OP_JSR,
        OP_RTS
    } op_kind_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TRAP,
        ST_JMP,
        ST_JS_LATCH,
        ST_JS_SPDEC,
        ST_JS_PUSH,
        ST_JS_LINK,
        ST_JS_PC,
        ST_RT_POP,
        ST_RT_SPINC,
        ST_RT_PC,
        ST_RT_LINK,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/jsl_decode.sv
// Instruction matcher: classifies a word as jump, call, return or other,
// and extracts the link register and whether a jump names a register.
// Assumes a 16-bit word; purely combinational.
module jsl_decode
    import jsl_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output op_kind_t           kind,
    output logic               reg_mode,
    output logic [REG_AW-1:0]  link_idx
);

    logic is_jmp;
    logic is_jsr;
    logic is_rts;

    // Match the three opcode patterns on their fixed bits.
    always_comb begin
        is_jmp = (instr[15:6] == 10'b0000000001);
        is_jsr = (instr[15:9] == 7'b0000100);
        is_rts = (instr[15:3] == 13'b0000000010000);
    end

    // Select the kind and pick the link field from its position.
    always_comb begin
        kind     = OP_NONE;
        link_idx = '0;
        if (is_jmp) begin
            kind = OP_JMP;
        end else if (is_jsr) begin
            kind     = OP_JSR;
            link_idx = instr[8:6];
        end else if (is_rts) begin
            kind     = OP_RTS;
            link_idx = instr[2:0];
        end
    end

    // Destination mode 0 means a register target.
    always_comb reg_mode = (instr[5:3] == 3'b000);

endmodule

// File: rtl/jsl_stack_step.sv
// Stack pointer arithmetic: next value for a push and for a pop.
// Assumes word-sized stack entries of STEP bytes; wraps modulo 2**DATA_W.
module jsl_stack_step #(
    parameter int DATA_W = 16,
    parameter int STEP   = 2
) (
    input  logic [DATA_W-1:0] sp,
    output logic [DATA_W-1:0] sp_push,
    output logic [DATA_W-1:0] sp_pop
);

    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    // Pre-decrement for a push, post-increment for a pop.
    always_comb begin
        sp_push = sp - STEP_V;
        sp_pop  = sp + STEP_V;
    end

endmodule

// File: rtl/jsl_seq.sv
// Sequencer: steps one instruction through its register writes and
// stack memory cycles, then pulses done. Assumes a combinational
// register read port and a memory that may acknowledge in the request cycle.
module jsl_seq
    import jsl_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int SP_IDX   = 6,
    parameter int PC_IDX   = 7,
    parameter int TRAP_VEC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  op_kind_t          kind,
    input  logic              reg_mode,
    input  logic [REG_AW-1:0] link_idx,
    input  logic [DATA_W-1:0] dest_addr,
    input  logic [DATA_W-1:0] rf_rd_data,
    input  logic [DATA_W-1:0] sp_push,
    input  logic [DATA_W-1:0] sp_pop,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done,
    output logic [REG_AW-1:0] rf_rd_idx,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_wr_idx,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              trap_req,
    output logic [DATA_W-1:0] trap_vector
);

    localparam logic [REG_AW-1:0] SP_R = REG_AW'(SP_IDX);
    localparam logic [REG_AW-1:0] PC_R = REG_AW'(PC_IDX);

    seq_state_t        state_q, state_d;
    logic [REG_AW-1:0] link_q;
    logic [DATA_W-1:0] dest_q;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] push_addr_q;

    // Choose the start state from the decoded instruction.
    function automatic seq_state_t entry_state(input op_kind_t k, input logic rm);
        case (k)
            OP_JMP:  return rm ? ST_TRAP : ST_JMP;
            OP_JSR:  return ST_JS_LATCH;
            OP_RTS:  return ST_RT_POP;
            default: return ST_DONE;
        endcase
    endfunction

    // Next state and all outputs for the current step.
    always_comb begin
        state_d     = state_q;
        rf_rd_idx   = SP_R;
        rf_we       = 1'b0;
        rf_wr_idx   = SP_R;
        rf_wr_data  = '0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        trap_req    = 1'b0;
        done        = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) state_d = entry_state(kind, reg_mode);
            end
            ST_TRAP: begin
                trap_req = 1'b1;
                state_d  = ST_DONE;
            end
            ST_JMP: begin
                rf_we      = 1'b1;
                rf_wr_idx  = PC_R;
                rf_wr_data = dest_q;
                state_d    = ST_DONE;
            end
            ST_JS_LATCH: begin
                rf_rd_idx = link_q;
                state_d   = ST_JS_SPDEC;
            end
            ST_JS_SPDEC: begin
                rf_rd_idx  = SP_R;
                rf_we      = 1'b1;
                rf_wr_idx  = SP_R;
                rf_wr_data = sp_push;
                state_d    = ST_JS_PUSH;
            end
            ST_JS_PUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = push_addr_q;
                mem_wdata = hold_q;
                if (mem_ack) state_d = ST_JS_LINK;
            end
            ST_JS_LINK: begin
                rf_rd_idx  = PC_R;
                rf_we      = 1'b1;
                rf_wr_idx  = link_q;
                rf_wr_data = rf_rd_data;
                state_d    = ST_JS_PC;
            end
            ST_JS_PC: begin
                rf_we      = 1'b1;
                rf_wr_idx  = PC_R;
                rf_wr_data = dest_q;
                state_d    = ST_DONE;
            end
            ST_RT_POP: begin
                rf_rd_idx = SP_R;
                mem_req   = 1'b1;
                mem_addr  = rf_rd_data;
                if (mem_ack) state_d = ST_RT_SPINC;
            end
            ST_RT_SPINC: begin
                rf_rd_idx  = SP_R;
                rf_we      = 1'b1;
                rf_wr_idx  = SP_R;
                rf_wr_data = sp_pop;
                state_d    = ST_RT_PC;
            end
            ST_RT_PC: begin
                rf_rd_idx  = link_q;
                rf_we      = 1'b1;
                rf_wr_idx  = PC_R;
                rf_wr_data = rf_rd_data;
                state_d    = ST_RT_LINK;
            end
            ST_RT_LINK: begin
                rf_we      = 1'b1;
                rf_wr_idx  = link_q;
                rf_wr_data = hold_q;
                state_d    = ST_DONE;
            end
            ST_DONE: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Busy flag and the vector shown alongside a trap request.
    always_comb begin
        busy        = (state_q != ST_IDLE);
        trap_vector = trap_req ? DATA_W'(TRAP_VEC) : '0;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture operands on acceptance, link value or popped word, push address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q      <= '0;
            dest_q      <= '0;
            hold_q      <= '0;
            push_addr_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                link_q <= link_idx;
                dest_q <= dest_addr;
            end
            if (state_q == ST_JS_LATCH)              hold_q      <= rf_rd_data;
            if (state_q == ST_RT_POP && mem_ack)     hold_q      <= mem_rdata;
            if (state_q == ST_JS_SPDEC)              push_addr_q <= sp_push;
        end
    end

endmodule

// File: rtl/jsl_unit.sv
// Top of the jump and subroutine linkage unit: decoder, stack arithmetic
// and sequencer. Assumes R6 is the stack pointer and R7 the PC, and that
// the destination address is already resolved when start is presented.
module jsl_unit
    import jsl_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int SP_IDX     = 6,
    parameter int PC_IDX     = 7,
    parameter int STACK_STEP = 2,
    parameter int TRAP_VEC   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  dest_addr,
    output logic               busy,
    output logic               done,
    output logic [REG_AW-1:0]  rf_rd_idx,
    input  logic [DATA_W-1:0]  rf_rd_data,
    output logic               rf_we,
    output logic [REG_AW-1:0]  rf_wr_idx,
    output logic [DATA_W-1:0]  rf_wr_data,
    output logic               mem_req,
    output logic               mem_we,
    output logic [DATA_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_ack,
    output logic               trap_req,
    output logic [DATA_W-1:0]  trap_vector
);

    op_kind_t          kind;
    logic              reg_mode;
    logic [REG_AW-1:0] link_idx;
    logic [DATA_W-1:0] sp_push;
    logic [DATA_W-1:0] sp_pop;

    jsl_decode u_dec (
        .instr    (instr),
        .kind     (kind),
        .reg_mode (reg_mode),
        .link_idx (link_idx)
    );

    jsl_stack_step #(.DATA_W(DATA_W), .STEP(STACK_STEP)) u_step (
        .sp      (rf_rd_data),
        .sp_push (sp_push),
        .sp_pop  (sp_pop)
    );

    jsl_seq #(
        .DATA_W   (DATA_W),
        .SP_IDX   (SP_IDX),
        .PC_IDX   (PC_IDX),
        .TRAP_VEC (TRAP_VEC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .kind        (kind),
        .reg_mode    (reg_mode),
        .link_idx    (link_idx),
        .dest_addr   (dest_addr),
        .rf_rd_data  (rf_rd_data),
        .sp_push     (sp_push),
        .sp_pop      (sp_pop),
        .mem_rdata   (mem_rdata),
        .mem_ack     (mem_ack),
        .busy        (busy),
        .done        (done),
        .rf_rd_idx   (rf_rd_idx),
        .rf_we       (rf_we),
        .rf_wr_idx   (rf_wr_idx),
        .rf_wr_data  (rf_wr_data),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .trap_req    (trap_req),
        .trap_vector (trap_vector)
    );

endmodule

// File: rtl/jsl_unit_chk.sv
// Property checker for jsl_unit, attached by bind. Observes ports only.
module jsl_unit_chk #(
    parameter int DATA_W   = 16,
    parameter int TRAP_VEC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              rf_we,
    input logic              mem_req,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              trap_req,
    input logic [DATA_W-1:0] trap_vector
);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (!rf_we && !mem_req && trap_vector == DATA_W'(TRAP_VEC)));

    // R3
    trap_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> done);

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R9
    write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || mem_req) |-> (busy && !done));

endmodule

bind jsl_unit jsl_unit_chk #(.DATA_W(DATA_W), .TRAP_VEC(TRAP_VEC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .rf_we       (rf_we),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .trap_req    (trap_req),
    .trap_vector (trap_vector)
);

// File: tb/tb_jsl_unit.sv
// Directed bench for jsl_unit with a register file and stack memory model.
module tb_jsl_unit;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [15:0]   instr = '0;
    logic [DW-1:0] dest_addr = '0;
    logic          busy, done, rf_we, mem_req, mem_we, mem_ack, trap_req;
    logic [2:0]    rf_rd_idx, rf_wr_idx;
    logic [DW-1:0] rf_rd_data, rf_wr_data, mem_addr, mem_wdata, mem_rdata, trap_vector;

    always #5 clk = ~clk;

    jsl_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .dest_addr(dest_addr),
        .busy(busy), .done(done), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .trap_req(trap_req), .trap_vector(trap_vector)
    );

    // Models and logs
    logic [DW-1:0] rf [0:7];
    logic [DW-1:0] mem [0:255];
    logic [2:0]    wl_idx [0:255];
    logic [DW-1:0] wl_dat [0:255];
    int wl_n = 0, mw_n = 0, mr_n = 0, mreq_n = 0, addr_moves = 0;
    int trap_n = 0, done_n = 0, cyc = 0, last_wr = -10, done_at = -10;
    logic [DW-1:0] trap_v = '0;
    int wait_cfg = 0, wcnt = 0;
    logic prev_pend = 1'b0;
    logic [DW-1:0] prev_addr = '0;
    logic ld_rf = 1'b0, ld_mem = 1'b0;
    logic [2:0] ld_idx = '0;
    logic [DW-1:0] ld_addr = '0, ld_val = '0;
    int checks = 0, errors = 0;

    assign rf_rd_data = rf[rf_rd_idx];
    assign mem_rdata  = mem[mem_addr[8:1]];
    assign mem_ack    = mem_req && (wcnt >= wait_cfg);

    // Register file, memory and observation log
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ld_rf) rf[ld_idx] <= ld_val;
        else if (rf_we) begin
            rf[rf_wr_idx] <= rf_wr_data;
            wl_idx[wl_n[7:0]] <= rf_wr_idx;
            wl_dat[wl_n[7:0]] <= rf_wr_data;
            wl_n <= wl_n + 1;
            last_wr <= cyc;
        end
        if (ld_mem) mem[ld_addr[8:1]] <= ld_val;
        else if (mem_req && mem_ack && mem_we) mem[mem_addr[8:1]] <= mem_wdata;
        if (mem_req) begin
            mreq_n <= mreq_n + 1;
            if (mem_ack) begin
                wcnt <= 0;
                if (mem_we) mw_n <= mw_n + 1; else mr_n <= mr_n + 1;
            end else wcnt <= wcnt + 1;
            if (prev_pend && mem_addr != prev_addr) addr_moves <= addr_moves + 1;
        end
        prev_pend <= mem_req && !mem_ack;
        prev_addr <= mem_addr;
        if (trap_req) begin trap_n <= trap_n + 1; trap_v <= trap_vector; end
        if (done) begin done_n <= done_n + 1; done_at <= cyc; end
    end

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic set_reg(input int idx, input int val);
        @(negedge clk); ld_rf = 1'b1; ld_idx = 3'(idx); ld_val = DW'(val);
        @(negedge clk); ld_rf = 1'b0;
    endtask

    task automatic set_mem(input int addr, input int val);
        @(negedge clk); ld_mem = 1'b1; ld_addr = DW'(addr); ld_val = DW'(val);
        @(negedge clk); ld_mem = 1'b0;
    endtask

    task automatic pulse_start(input logic [15:0] iw, input int dst);
        @(negedge clk); start = 1'b1; instr = iw; dest_addr = DW'(dst);
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(input int base, input string rq);
        int t = 0;
        while (done_n == base && t < 100) begin @(negedge clk); t++; end
        chk(rq, "done seen", int'(done_n != base), 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_wr(input int k, input int idx, input int val, input string rq);
        chk(rq, $sformatf("write %0d index", k), int'(wl_idx[k[7:0]]), idx);
        chk(rq, $sformatf("write %0d data", k), int'(wl_dat[k[7:0]]), val);
    endtask

    task automatic test_reset();
        // R1
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done/we/req/trap", int'({done, rf_we, mem_req, trap_req}), 0);
    endtask

    task automatic test_jmp();
        int w0 = wl_n, d0 = done_n, m0 = mreq_n, t0 = trap_n;
        set_reg(7, 16'h0100);
        w0 = wl_n;
        pulse_start(16'h004A, 16'h1234);
        wait_done(d0, "R2");
        chk("R2", "write count", wl_n - w0, 1);
        chk_wr(w0, 7, 16'h1234, "R2");
        chk("R2", "no memory/trap", (mreq_n - m0) + (trap_n - t0), 0);
        chk("R9", "done after last write", done_at, last_wr + 1);
        chk("R9", "single done", done_n - d0, 1);
    endtask

    task automatic test_jmp_reg();
        int w0 = wl_n, d0 = done_n, m0 = mreq_n, t0 = trap_n;
        pulse_start(16'h0043, 16'h7777);
        wait_done(d0, "R3");
        chk("R3", "trap count", trap_n - t0, 1);
        chk("R3", "trap vector", int'(trap_v), 8);
        chk("R3", "no writes", wl_n - w0, 0);
        chk("R3", "no memory", mreq_n - m0, 0);
        chk("R3", "PC kept", int'(rf[7]), 16'h1234);
    endtask

    task automatic test_jsr();
        int w0, d0, m0;
        set_reg(5, 16'h1111); set_reg(6, 16'h0100); set_reg(7, 16'h0500);
        wait_cfg = 0;
        w0 = wl_n; d0 = done_n; m0 = mw_n;
        pulse_start(16'h0977, 16'h2000);
        wait_done(d0, "R4");
        chk("R4", "write count", wl_n - w0, 3);
        chk_wr(w0, 6, 16'h00FE, "R4");
        chk("R4", "pushed word", int'(mem[8'h7F]), 16'h1111);
        chk("R4", "one push", mw_n - m0, 1);
        chk_wr(w0 + 1, 5, 16'h0500, "R5");
        chk_wr(w0 + 2, 7, 16'h2000, "R5");
        chk("R9", "done after last write", done_at, last_wr + 1);
    endtask

    task automatic test_jsr_pc();
        int w0, d0, q0;
        set_reg(6, 16'h00FE); set_reg(7, 16'h0600);
        wait_cfg = 2;
        w0 = wl_n; d0 = done_n; q0 = mreq_n;
        pulse_start(16'h09DF, 16'h3000);
        wait_done(d0, "R5");
        chk_wr(w0, 6, 16'h00FC, "R5");
        chk_wr(w0 + 1, 7, 16'h0600, "R5");
        chk_wr(w0 + 2, 7, 16'h3000, "R5");
        chk("R5", "final PC", int'(rf[7]), 16'h3000);
        chk("R4", "pushed PC", int'(mem[8'h7E]), 16'h0600);
        chk("R8", "request cycles with 2 waits", mreq_n - q0, 3);
    endtask

    task automatic test_rts();
        int w0, d0, r0, q0, a0;
        set_mem(16'h00FC, 16'hABCD);
        set_reg(5, 16'h0777); set_reg(6, 16'h00FC); set_reg(7, 16'h0900);
        wait_cfg = 3;
        w0 = wl_n; d0 = done_n; r0 = mr_n; q0 = mreq_n; a0 = addr_moves;
        pulse_start(16'h0085, 16'h5555);
        wait_done(d0, "R6");
        chk("R6", "write count", wl_n - w0, 3);
        chk_wr(w0, 6, 16'h00FE, "R6");
        chk_wr(w0 + 1, 7, 16'h0777, "R6");
        chk_wr(w0 + 2, 5, 16'hABCD, "R6");
        chk("R8", "one pop", mr_n - r0, 1);
        chk("R8", "request cycles with 3 waits", mreq_n - q0, 4);
        chk("R8", "address held", addr_moves - a0, 0);
    endtask

    task automatic test_rts_pc();
        int w0, d0;
        set_mem(16'h00FE, 16'h4242);
        set_reg(6, 16'h00FE); set_reg(7, 16'h0A00);
        wait_cfg = 0;
        w0 = wl_n; d0 = done_n;
        pulse_start(16'h0087, 16'h0);
        wait_done(d0, "R7");
        chk_wr(w0, 6, 16'h0100, "R7");
        chk_wr(w0 + 1, 7, 16'h0A00, "R7");
        chk_wr(w0 + 2, 7, 16'h4242, "R7");
        chk("R7", "final PC", int'(rf[7]), 16'h4242);
        chk("R9", "done after last write", done_at, last_wr + 1);
    endtask

    task automatic test_other(input logic [15:0] iw);
        int w0 = wl_n, d0 = done_n, q0 = mreq_n, t0 = trap_n;
        pulse_start(iw, 16'hFFFF);
        wait_done(d0, "R10");
        chk("R10", $sformatf("no effect for 0x%0h", iw),
            (wl_n - w0) + (mreq_n - q0) + (trap_n - t0), 0);
        chk("R10", "single done", done_n - d0, 1);
    endtask

    task automatic test_busy_start();
        int w0, d0;
        set_reg(5, 16'h0001); set_reg(6, 16'h0100); set_reg(7, 16'h0500);
        wait_cfg = 4;
        w0 = wl_n; d0 = done_n;
        pulse_start(16'h0977, 16'h2468);
        @(negedge clk);
        pulse_start(16'h004A, 16'hDEAD);
        wait_done(d0, "R11");
        repeat (6) @(negedge clk);
        chk("R11", "single done", done_n - d0, 1);
        chk("R11", "write count", wl_n - w0, 3);
        chk("R11", "final PC", int'(rf[7]), 16'h2468);
        chk("R11", "not busy", int'(busy), 0);
    endtask

    // Watchdog
    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Main sequence
    initial begin
        for (int i = 0; i < 8; i++) rf[i] = '0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_jmp();
        test_jmp_reg();
        test_jsr();
        test_jsr_pc();
        test_rts();
        test_rts_pc();
        test_other(16'h0088);
        test_other(16'h0A00);
        test_busy_start();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule